// File: doc/BRIEF.md
# Instruction Queue with Kill and Clog Control

This block is a circular instruction queue that sits in front of a port executor. Instructions are written at the tail, and the executor receives them from the head, one at a time. Each instruction is delivered with a valid/ready handshake. The executor later signals completion with a retire strobe. Ordinary instructions leave in exactly the order they arrived.

Three control instructions are handled inside the queue and never reach the executor:

- **Kill.** When a kill reaches the head, it moves into a side counter. It then discards the next `n` instructions that reach the head, whether they are already queued or arrive later.
- **Clog.** A clog at the head blocks all delivery.
- **Unclog.** An unclog offered at the input is not stored. It waits at the input until a clog occupies the head. Both then retire in the same cycle.

The opcode field is the top two bits of every instruction word: `00` normal, `01` kill, `10` clog, `11` unclog. A kill carries its count in the low `CNT_W` bits.

Top module: `instr_queue`

## Requirements
- R1: After reset the queue is empty. `outValid` is 0, and `inReady` is 1 for any non-unclog instruction.
- R2: Normal instructions (opcode `00`) reach `outInstr` in the order they were accepted, each exactly once.
- R3: The queue accepts `DEPTH` instructions and then holds `inReady` low for any non-unclog instruction until an entry leaves.
- R4: After an output handshake, `outValid` stays low until `retire` is pulsed. A `retire` pulse with nothing in flight has no effect.
- R5: While `outValid` is high and `outReady` is low, `outInstr` holds its value and `outValid` stays high.
- R6: A kill (opcode `01`) with count `n` in bits `[CNT_W-1:0]` discards the `n` instructions that follow it, and none of them is presented. A count of 0 discards nothing.
- R7: A kill whose victims have not yet arrived waits, then discards the next `n` instructions that enter, with no interleaving.
- R8: A clog (opcode `10`) at the head keeps `outValid` low.
- R9: An unclog (opcode `11`) at the input sees `inReady` low until a clog is at the head. When it is accepted, the clog retires in the same cycle and the instructions after the clog are delivered.
- R10: While an unclog is stalled at the input, it is never accepted, whatever else the queue does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Instruction offered at the tail |
| inReady | output | 1 | Tail accepts the offered instruction |
| inInstr | input | INSTR_W | Offered instruction word |
| outValid | output | 1 | Normal instruction presented to the executor |
| outReady | input | 1 | Executor takes the presented instruction |
| outInstr | output | INSTR_W | Presented instruction word |
| retire | input | 1 | Executor has finished the instruction in flight |

## Verification
The bench aims a kill at victims that are already queued and, separately, at victims that arrive several cycles later. An off-by-one counter would leak or swallow one instruction in either case, and a kill that gives up on an empty queue would let the late victims through. A clog is placed behind a normal instruction while an unclog waits at the input. A design that stores the unclog, or that matches it against something other than a clog at the head, would accept it early or deliver the instruction behind the clog too soon. Filling the queue to capacity catches wrap-bit mistakes that corrupt the full flag or the read order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    OP_NORMAL = 2'b00,
    OP_KILL   = 2'b01,
    OP_CLOG   = 2'b10,
    OP_UNCLOG = 2'b11
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic loadKill;
    logic decKill;
  } qStrobe_t;
endpackage

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  qStrobe_t           strb,
  input  logic [INSTR_W-1:0] inInstr,
  output logic [INSTR_W-1:0] headInstr,
  output logic               empty,
  output logic               full,
  output logic [CNT_W-1:0]   killCnt
);
  localparam int AW = $clog2(DEPTH);

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr[AW-1:0]] <= inInstr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      killCnt <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      if (strb.loadKill)     killCnt <= headInstr[CNT_W-1:0];
      else if (strb.decKill) killCnt <= killCnt - 1'b1;
    end
  end

  // the extra top bit of each pointer tells a full queue from an empty one
  assign headInstr = mem[rdPtr[AW-1:0]];
  assign empty     = (wrPtr == rdPtr);
  assign full      = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
  import iq_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inInstr,
  output logic               inReady,
  output logic               outValid,
  input  logic               outReady,
  input  logic               retire,
  input  logic [INSTR_W-1:0] headInstr,
  input  logic               empty,
  input  logic               full,
  input  logic [CNT_W-1:0]   killCnt,
  output qStrobe_t           strb
);
  opKind_t headOp, inOp;
  logic killOn, headKill, headClog, isUnclog, unclogHit, deliver, busy;

  assign headOp    = opKind_t'(headInstr[INSTR_W-1 -: 2]);
  assign inOp      = opKind_t'(inInstr[INSTR_W-1 -: 2]);
  assign killOn    = (killCnt != '0);
  assign headKill  = !killOn && !empty && (headOp == OP_KILL);
  assign headClog  = !killOn && !empty && (headOp == OP_CLOG);
  assign isUnclog  = (inOp == OP_UNCLOG);
  assign unclogHit = inValid && isUnclog && headClog;

  // an unclog is never stored: it waits for a clog at the head
  assign inReady  = isUnclog ? headClog : !full;
  assign outValid = !empty && !killOn && (headOp == OP_NORMAL) && !busy;
  assign deliver  = outValid && outReady;

  always_comb begin
    strb          = '0;
    strb.push     = inValid && inReady && !isUnclog;
    strb.loadKill = headKill;
    strb.decKill  = killOn && !empty;
    strb.pop      = strb.decKill || headKill || unclogHit || deliver;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busy <= 1'b0;
    else if (deliver) busy <= 1'b1;
    else if (retire)  busy <= 1'b0;
  end
endmodule

// File: rtl/instr_queue.sv
module instr_queue
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [INSTR_W-1:0] inInstr,
  output logic               outValid,
  input  logic               outReady,
  output logic [INSTR_W-1:0] outInstr,
  input  logic               retire
);
  qStrobe_t           strb;
  logic [INSTR_W-1:0] headInstr;
  logic               emptyW, fullW;
  logic [CNT_W-1:0]   killCnt;

  iq_store #(.DEPTH(DEPTH), .INSTR_W(INSTR_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inInstr(inInstr),
    .headInstr(headInstr), .empty(emptyW), .full(fullW), .killCnt(killCnt)
  );

  iq_ctrl #(.INSTR_W(INSTR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inInstr(inInstr),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .retire(retire), .headInstr(headInstr), .empty(emptyW), .full(fullW),
    .killCnt(killCnt), .strb(strb)
  );

  assign outInstr = headInstr;
endmodule

// File: rtl/iq_checker.sv
module iq_checker
  import iq_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic [INSTR_W-1:0] inInstr,
  input logic               outValid,
  input logic               outReady,
  input logic [INSTR_W-1:0] outInstr,
  input logic               push,
  input logic               fullW,
  input logic               emptyW,
  input logic [CNT_W-1:0]   killCnt
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !fullW);

  p_one_in_flight_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);

  p_hold_output_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outInstr)));

  p_only_normal_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outInstr[INSTR_W-1 -: 2] == 2'b00));

  p_kill_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((killCnt != '0) && !emptyW) |=> (killCnt == $past(killCnt) - 1'b1));

  p_kill_silences_r7: assert property (@(posedge clk) disable iff (!rstN)
    (killCnt != '0) |-> !outValid);

  p_unclog_meets_clog_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inInstr[INSTR_W-1 -: 2] == 2'b11)) |->
      (!outValid && (outInstr[INSTR_W-1 -: 2] == 2'b10) && !emptyW));
endmodule

bind instr_queue iq_checker #(.INSTR_W(INSTR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inInstr(inInstr), .outValid(outValid), .outReady(outReady),
  .outInstr(outInstr), .push(strb.push), .fullW(fullW), .emptyW(emptyW),
  .killCnt(killCnt)
);

// File: tb/instr_queue_tb_top.sv
`timescale 1ns/1ps
module instr_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int IW    = 16;
  localparam int CW    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0, retire = 1'b0;
  logic [IW-1:0] inInstr = '0;
  logic inReady, outValid;
  logic [IW-1:0] outInstr;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk; // 125 MHz

  instr_queue #(.DEPTH(DEPTH), .INSTR_W(IW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inInstr(inInstr), .outValid(outValid), .outReady(outReady),
    .outInstr(outInstr), .retire(retire)
  );

  function automatic logic [IW-1:0] norm(input int v);
    return {2'b00, 14'(v)};
  endfunction
  function automatic logic [IW-1:0] killN(input int n);
    return {2'b01, 8'h00, 6'(n)};
  endfunction
  localparam logic [IW-1:0] CLOG   = 16'h8000;
  localparam logic [IW-1:0] UNCLOG = 16'hC000;

  task automatic check(input logic ok, input string req, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pushOne(input logic [IW-1:0] ins);
    @(negedge clk);
    inValid = 1'b1; inInstr = ins;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drainOne(input logic [IW-1:0] exp, input string req);
    @(negedge clk); #1;
    for (int i = 0; i < 30 && !outValid; i++) begin @(negedge clk); #1; end
    check(outValid && outInstr == exp, req, outInstr, exp);
    outReady = 1'b1;
    @(posedge clk); #1;
    outReady = 1'b0;
    check(!outValid, "R4 busy until retire", IW'(outValid), '0);
    @(negedge clk); retire = 1'b1;
    @(posedge clk); #1; retire = 1'b0;
  endtask

  task automatic expectIdle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check(!outValid, req, IW'(outValid), '0);
    end
  endtask

  task automatic testReset();
    inInstr = norm(1);
    #1;
    check(!outValid, "R1 outValid after reset", IW'(outValid), '0);
    check(inReady, "R1 inReady after reset", IW'(inReady), 1);
    inInstr = '0;
  endtask

  task automatic testOrder();
    logic [IW-1:0] first;
    // a retire with nothing in flight must not disturb anything
    @(negedge clk); retire = 1'b1; @(posedge clk); #1; retire = 1'b0;
    pushOne(norm(11)); pushOne(norm(12)); pushOne(norm(13));
    @(negedge clk); #1;
    first = outInstr;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      check(outValid && outInstr == first, "R5 held output", outInstr, first);
    end
    drainOne(norm(11), "R2 order 1st");
    drainOne(norm(12), "R2 order 2nd");
    drainOne(norm(13), "R2 order 3rd");
    expectIdle(2, "R4 stray retire adds nothing");
  endtask

  task automatic testFull();
    for (int i = 0; i < DEPTH; i++) pushOne(norm(100 + i));
    @(negedge clk); inValid = 1'b1; inInstr = norm(999); #1;
    check(!inReady, "R3 full blocks input", IW'(inReady), '0);
    inValid = 1'b0;
    for (int i = 0; i < DEPTH; i++) drainOne(norm(100 + i), "R3 full drain order");
  endtask

  task automatic testKill();
    pushOne(killN(2)); pushOne(norm(21)); pushOne(norm(22)); pushOne(norm(23));
    drainOne(norm(23), "R6 kill 2 discards two");
    pushOne(killN(0)); pushOne(norm(24));
    drainOne(norm(24), "R6 kill 0 discards none");
  endtask

  task automatic testLateKill();
    pushOne(killN(2));
    expectIdle(5, "R7 kill waiting");
    pushOne(norm(31)); pushOne(norm(32)); pushOne(norm(33));
    drainOne(norm(33), "R7 late victims discarded");
  endtask

  task automatic testClog();
    pushOne(CLOG); pushOne(norm(41));
    expectIdle(4, "R8 clog blocks");
    pushOne(UNCLOG);
    drainOne(norm(41), "R9 delivery after unclog");
  endtask

  task automatic testUnclogStall();
    pushOne(norm(51)); pushOne(CLOG); pushOne(norm(52));
    @(negedge clk); inValid = 1'b1; inInstr = UNCLOG;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(!inReady, "R10 unclog stalled", IW'(inReady), '0);
      @(negedge clk);
    end
    inValid = 1'b0;
    drainOne(norm(51), "R9 instruction ahead of clog");
    expectIdle(2, "R8 clog at head");
    @(negedge clk); inValid = 1'b1; inInstr = UNCLOG; #1;
    check(inReady, "R9 unclog meets clog", IW'(inReady), 1);
    @(posedge clk); #1; inValid = 1'b0;
    drainOne(norm(52), "R9 after clog retired");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testOrder();
    testFull();
    testKill();
    testLateKill();
    testClog();
    testUnclogStall();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule